// File: doc/BRIEF.md
# Sideband Configuration-Read Command Handler

This block serves one sideband command that reads a 32-bit word from a downstream configuration space. A framing layer passes it a byte stream. The stream holds two header bytes, the declared write length and the declared read length, followed by the six write bytes: the command code, a host-ID/retry byte and four address bytes that arrive least significant byte first. The block checks the header and the command code. If any of them is wrong, it drops the transaction and pulses an abort flag back to the framing layer.

For a valid command, the block splits the address into bus, device, function and register-offset fields and raises a request on a simple request/acknowledge configuration port. It then waits for an acknowledge, or for a timeout. The reply is five bytes on a byte-wide valid/ready output: a completion code, then the 32-bit data, least significant byte first. The block accepts no new input from the last command byte until the last reply byte has been taken.

Top module: `cfgrd_cmd_handler`

## Requirements
- R1: After reset, in_ready is 1, and busy, out_valid, abort and cfg_req are 0.
- R2: The first header byte (write length) must be 0x06 and the second (read length) must be 0x05. Any other value produces a one-cycle abort pulse in the cycle after that byte is accepted. No configuration request follows, and the next byte is taken as a new write-length byte.
- R3: The third byte (command code) must be 0x61. Any other value aborts in the same way as R2.
- R4: The four address bytes arrive least significant first. While cfg_req is high, cfg_bus carries address bits 27:20, cfg_dev bits 19:15, cfg_func bits 14:12 and cfg_reg bits 11:0. Address bits 31:28 are ignored.
- R5: cfg_req rises after a valid command and stays high, with stable address fields, until cfg_ack is sampled high or the timeout expires. It drops in the cycle after the acknowledge.
- R6: The reply is five bytes: completion code first, then the data, least significant byte first. An acknowledge with cfg_unimpl low gives code 0x40 and cfg_rdata, even when that data is all ones.
- R7: An acknowledge with cfg_unimpl high gives code 0x90 (invalid request) and data 0xFFFFFFFF.
- R8: If no acknowledge arrives while cfg_req has been high for TIMEOUT_CYC cycles, cfg_req drops and the reply is code 0x80 with data 0xFFFFFFFF. An acknowledge in the last of those cycles still gives code 0x40.
- R9: From the acceptance of the last command byte until the last reply byte is taken, in_ready is 0 and busy is 1. in_ready and out_valid are never high together.
- R10: While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R11: The host-ID/retry byte (fourth byte) has no effect on the request or on the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take an input byte |
| abort | output | 1 | One-cycle pulse: transaction discarded |
| busy | output | 1 | A transaction is in progress |
| cfg_req | output | 1 | Configuration read request |
| cfg_bus | output | 8 | Bus number of the request |
| cfg_dev | output | 5 | Device number of the request |
| cfg_func | output | 3 | Function number of the request |
| cfg_reg | output | 12 | Register offset of the request |
| cfg_ack | input | 1 | Configuration port completed the read |
| cfg_unimpl | input | 1 | With cfg_ack: register not implemented |
| cfg_rdata | input | 32 | Read data, valid with cfg_ack |
| out_valid | output | 1 | Reply byte valid |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Consumer takes the reply byte |

## Verification
The assertions check the cycle-level invariants on every cycle. The output byte must hold under backpressure. Input and output must never be open together. The address fields must stay stable while a request is outstanding. The timeout counter must stay in range. An abort must never coincide with a request, and an invalid-request reply must carry all-ones data. Only the bench scenarios can show the rest: the byte order of the address and the reply, the field decode, which completion code each outcome produces, the exact timeout boundary, and the fact that the block recovers after an abort and that the host-ID byte has no effect.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 4;
  localparam int DATA_BYTES = 4;
  localparam int WR_BYTES   = 6;
  localparam int HDR_BYTES  = 2;

  localparam logic [7:0] WLEN_OK   = 8'h06;
  localparam logic [7:0] RLEN_OK   = 8'h05;
  localparam logic [7:0] OPC_CFGRD = 8'h61;
  localparam logic [7:0] CC_PASS   = 8'h40;
  localparam logic [7:0] CC_NORESP = 8'h80;
  localparam logic [7:0] CC_BADREQ = 8'h90;

  typedef enum logic [1:0] {PH_RX, PH_EXEC, PH_TX} phase_e;

  // configuration location, address bits 27:0
  typedef struct packed {
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  func;
    logic [11:0] regoff;
  } cfg_loc_t;
endpackage

// File: rtl/cfgrd_rx.sv
module cfgrd_rx
  import cfgrd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        take,
  input  logic [BYTE_W-1:0]           din,
  output logic                        last,
  output logic                        cmd_ok,
  output logic                        abort,
  output logic                        mid,
  output logic [ADDR_BYTES*BYTE_W-1:0] addr
);
  localparam int LAST_IDX = HDR_BYTES + WR_BYTES - 1;
  localparam int CNT_W    = $clog2(LAST_IDX + 1);
  localparam logic [CNT_W-1:0] IDX_LAST  = CNT_W'(LAST_IDX);
  localparam logic [CNT_W-1:0] IDX_ADDR0 = CNT_W'(LAST_IDX - ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] IDX_WLEN  = CNT_W'(0);
  localparam logic [CNT_W-1:0] IDX_RLEN  = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_OPC   = CNT_W'(2);

  logic [CNT_W-1:0] cnt;
  logic             bad;

  always_comb begin
    bad = 1'b0;
    if (cnt == IDX_WLEN && din != WLEN_OK)  bad = 1'b1;
    if (cnt == IDX_RLEN && din != RLEN_OK)  bad = 1'b1;
    if (cnt == IDX_OPC  && din != OPC_CFGRD) bad = 1'b1;
  end

  assign last = take && (cnt == IDX_LAST);
  assign mid  = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cmd_ok <= 1'b0;
      abort  <= 1'b0;
      addr   <= '0;
    end else begin
      cmd_ok <= 1'b0;
      abort  <= 1'b0;
      if (take) begin
        if (bad) begin
          abort <= 1'b1;
          cnt   <= '0;
        end else if (cnt == IDX_LAST) begin
          cmd_ok <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (cnt >= IDX_ADDR0)
          addr <= {din, addr[ADDR_BYTES*BYTE_W-1:BYTE_W]};
      end
    end
  end

  // R2
  abort_vs_ok_chk: assert property (@(posedge clk) disable iff (rst)
    !(abort && cmd_ok));
endmodule

// File: rtl/cfgrd_port.sv
module cfgrd_port
  import cfgrd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  cfg_loc_t                     loc_in,
  input  logic                         cfg_ack,
  input  logic                         cfg_unimpl,
  input  logic [DATA_BYTES*BYTE_W-1:0] cfg_rdata,
  output logic                         cfg_req,
  output cfg_loc_t                     loc,
  output logic                         done,
  output logic [BYTE_W-1:0]            cc,
  output logic [DATA_BYTES*BYTE_W-1:0] rdata
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_req <= 1'b0;
      loc     <= '0;
      tcnt    <= '0;
      done    <= 1'b0;
      cc      <= '0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (!cfg_req) begin
        if (start) begin
          cfg_req <= 1'b1;
          loc     <= loc_in;
          tcnt    <= '0;
        end
      end else if (cfg_ack) begin
        cfg_req <= 1'b0;
        done    <= 1'b1;
        if (cfg_unimpl) begin
          cc    <= CC_BADREQ;
          rdata <= '1;
        end else begin
          cc    <= CC_PASS;
          rdata <= cfg_rdata;
        end
      end else if (tcnt == TLIM) begin
        cfg_req <= 1'b0;
        done    <= 1'b1;
        cc      <= CC_NORESP;
        rdata   <= '1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R5
  loc_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && $past(cfg_req)) |-> $stable(loc));
  // R8
  tout_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> (tcnt <= TLIM));
  // R7
  badreq_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cc == CC_BADREQ) |-> (rdata == '1));
endmodule

// File: rtl/cfgrd_tx.sv
module cfgrd_tx
  import cfgrd_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [BYTE_W-1:0]            cc,
  input  logic [DATA_BYTES*BYTE_W-1:0] data,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [BYTE_W-1:0]            out_data,
  output logic                         last
);
  localparam int SH_W  = (DATA_BYTES + 1) * BYTE_W;
  localparam int REM_W = $clog2(DATA_BYTES + 1);
  localparam logic [REM_W-1:0] REM_FULL = REM_W'(DATA_BYTES);

  logic [SH_W-1:0]  sh;
  logic [REM_W-1:0] rem;

  assign out_data = sh[BYTE_W-1:0];
  assign last     = out_valid && out_ready && (rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      rem       <= '0;
      out_valid <= 1'b0;
    end else if (load) begin
      sh        <= {data, cc};
      rem       <= REM_FULL;
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      if (rem == '0) begin
        out_valid <= 1'b0;
      end else begin
        sh  <= sh >> BYTE_W;
        rem <= rem - 1'b1;
      end
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/cfgrd_cmd_handler.sv
module cfgrd_cmd_handler
  import cfgrd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        abort,
  output logic        busy,
  output logic        cfg_req,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_func,
  output logic [11:0] cfg_reg,
  input  logic        cfg_ack,
  input  logic        cfg_unimpl,
  input  logic [31:0] cfg_rdata,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready
);
  localparam int LOC_W = $bits(cfg_loc_t);

  phase_e phase;
  logic   take, rx_last, rx_ok, rx_mid, p_done, tx_last;
  logic [ADDR_BYTES*BYTE_W-1:0] rx_addr;
  logic [BYTE_W-1:0]            p_cc;
  logic [DATA_BYTES*BYTE_W-1:0] p_data;
  cfg_loc_t loc;

  assign in_ready = (phase == PH_RX);
  assign take     = in_valid && in_ready;
  assign busy     = (phase != PH_RX) || rx_mid;
  assign cfg_bus  = loc.bus;
  assign cfg_dev  = loc.dev;
  assign cfg_func = loc.func;
  assign cfg_reg  = loc.regoff;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_RX;
    else begin
      case (phase)
        PH_RX:   if (rx_last) phase <= PH_EXEC;
        PH_EXEC: if (p_done)  phase <= PH_TX;
        PH_TX:   if (tx_last) phase <= PH_RX;
        default: phase <= PH_RX;
      endcase
    end
  end

  cfgrd_rx u_rx (
    .clk(clk), .rst(rst), .take(take), .din(in_data),
    .last(rx_last), .cmd_ok(rx_ok), .abort(abort), .mid(rx_mid), .addr(rx_addr)
  );

  cfgrd_port #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_port (
    .clk(clk), .rst(rst), .start(rx_ok), .loc_in(cfg_loc_t'(rx_addr[LOC_W-1:0])),
    .cfg_ack(cfg_ack), .cfg_unimpl(cfg_unimpl), .cfg_rdata(cfg_rdata),
    .cfg_req(cfg_req), .loc(loc), .done(p_done), .cc(p_cc), .rdata(p_data)
  );

  cfgrd_tx u_tx (
    .clk(clk), .rst(rst), .load(p_done), .cc(p_cc), .data(p_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .last(tx_last)
  );

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
  // R2
  abort_noreq_chk: assert property (@(posedge clk) disable iff (rst)
    abort |-> !cfg_req);
endmodule

// File: tb/sim_cfgrd_cmd_handler.sv
module sim_cfgrd_cmd_handler;
  localparam int CLK_PERIOD = 10;
  localparam int TOUT = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0; logic [7:0] in_data = '0;
  logic in_ready, abort, busy, cfg_req;
  logic [7:0] cfg_bus; logic [4:0] cfg_dev; logic [2:0] cfg_func; logic [11:0] cfg_reg;
  logic cfg_ack = 1'b0, cfg_unimpl = 1'b0; logic [31:0] cfg_rdata = '0;
  logic out_valid; logic [7:0] out_data; logic out_ready = 1'b0;

  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgrd_cmd_handler #(.TIMEOUT_CYC(TOUT)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .abort(abort), .busy(busy), .cfg_req(cfg_req), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_ack(cfg_ack), .cfg_unimpl(cfg_unimpl),
    .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the handshake
  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] host, input logic [31:0] addr);
    send_byte(8'h06); send_byte(8'h05); send_byte(8'h61); send_byte(host);
    for (int i = 0; i < 4; i++) send_byte(addr[8*i +: 8]);
  endtask

  task automatic wait_req();
    int n = 0;
    while (!cfg_req && n < 50) begin @(negedge clk); n++; end
  endtask

  // delay 0: never acknowledge
  task automatic respond(input string tag, input logic [31:0] addr, input int delay,
                         input logic unimpl, input logic [31:0] rd);
    int seen;
    wait_req();
    chk({tag, " R5 req raised"}, cfg_req, 1);
    chk({tag, " R4 bus"},  cfg_bus,  addr[27:20]);
    chk({tag, " R4 dev"},  cfg_dev,  addr[19:15]);
    chk({tag, " R4 func"}, cfg_func, addr[14:12]);
    chk({tag, " R4 reg"},  cfg_reg,  addr[11:0]);
    chk({tag, " R9 in_ready low"}, in_ready, 0);
    chk({tag, " R9 busy high"}, busy, 1);
    if (delay == 0) begin
      seen = 1;
      @(negedge clk);
      while (cfg_req && seen < 100) begin seen++; @(negedge clk); end
      chk({tag, " R8 req cycles"}, seen, TOUT);
    end else begin
      for (int k = 1; k < delay; k++) @(negedge clk);
      cfg_ack = 1'b1; cfg_unimpl = unimpl; cfg_rdata = rd;
      @(negedge clk);
      cfg_ack = 1'b0; cfg_unimpl = 1'b0; cfg_rdata = 32'h5A5A5A5A;
      chk({tag, " R5 req dropped"}, cfg_req, 0);
    end
  endtask

  task automatic recv_reply(input string tag, input int stall,
                            input logic [7:0] exp_cc, input logic [31:0] exp_d);
    logic [39:0] got;
    logic [7:0]  first;
    for (int i = 0; i < 5; i++) begin
      int n = 0;
      while (!out_valid && n < 50) begin @(negedge clk); n++; end
      first = out_data;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk({tag, " R10 hold valid"}, out_valid, 1);
        chk({tag, " R10 hold data"}, out_data, first);
      end
      if (i == 1) chk({tag, " R9 in_ready low in reply"}, in_ready, 0);
      out_ready = 1'b1;
      got[8*i +: 8] = out_data;
      @(posedge clk); @(negedge clk);
      out_ready = 1'b0;
    end
    chk({tag, " R6 code"}, got[7:0], exp_cc);
    chk({tag, " R6 data"}, got[39:8], exp_d);
    chk({tag, " R9 idle after reply"}, {busy, in_ready, out_valid}, 3'b010);
  endtask

  task automatic do_read(input string tag, input logic [7:0] host, input logic [31:0] addr,
                         input int delay, input logic unimpl, input logic [31:0] rd,
                         input logic [7:0] exp_cc, input logic [31:0] exp_d, input int stall);
    send_cmd(host, addr);
    respond(tag, addr, delay, unimpl, rd);
    recv_reply(tag, stall, exp_cc, exp_d);
  endtask

  task automatic expect_abort(input string tag);
    chk({tag, " abort pulse"}, abort, 1);
    @(negedge clk);
    chk({tag, " abort one cycle"}, abort, 0);
    for (int i = 0; i < 6; i++) begin
      chk({tag, " no request"}, cfg_req, 0);
      @(negedge clk);
    end
    chk({tag, " idle after abort"}, {busy, in_ready}, 2'b01);
  endtask

  task automatic t_reset();
    chk("R1 in_ready", in_ready, 1);
    chk("R1 busy", busy, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 abort", abort, 0);
    chk("R1 cfg_req", cfg_req, 0);
  endtask

  task automatic t_bad_wlen();
    send_byte(8'h07);
    expect_abort("R2 wlen");
    do_read("R2 recover", 8'h00, 32'h0012_3004, 2, 1'b0, 32'h0BAD_F00D, 8'h40, 32'h0BAD_F00D, 0);
  endtask

  task automatic t_bad_rlen();
    send_byte(8'h06); send_byte(8'h04);
    expect_abort("R2 rlen");
  endtask

  task automatic t_bad_cmd();
    send_byte(8'h06); send_byte(8'h05); send_byte(8'h60);
    expect_abort("R3 cmd");
    do_read("R3 recover", 8'h11, 32'h0000_8010, 1, 1'b0, 32'h1357_9BDF, 8'h40, 32'h1357_9BDF, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // addr = rsvd F, bus 3A, dev 1F, func 5, reg ABC
    do_read("R4 R6 pass", 8'h00, {4'hF, 8'h3A, 5'h1F, 3'h5, 12'hABC}, 3, 1'b0,
            32'h1234_5678, 8'h40, 32'h1234_5678, 0);
    do_read("R11 host id", 8'hA5, {4'hF, 8'h3A, 5'h1F, 3'h5, 12'hABC}, 3, 1'b0,
            32'h1234_5678, 8'h40, 32'h1234_5678, 2);
    do_read("R10 stall", 8'h3C, {4'h0, 8'hC5, 5'h0A, 3'h2, 12'h105}, 1, 1'b0,
            32'hCAFE_F00D, 8'h40, 32'hCAFE_F00D, 3);
    do_read("R7 unimpl", 8'h00, {4'h0, 8'h01, 5'h02, 3'h3, 12'h0FC}, 2, 1'b1,
            32'h0123_4567, 8'h90, 32'hFFFF_FFFF, 0);
    do_read("R6 ones pass", 8'h00, {4'h0, 8'hFF, 5'h1F, 3'h7, 12'hFFF}, 4, 1'b0,
            32'hFFFF_FFFF, 8'h40, 32'hFFFF_FFFF, 0);
    do_read("R8 last cycle ack", 8'h00, 32'h0055_5000, TOUT, 1'b0,
            32'h8765_4321, 8'h40, 32'h8765_4321, 0);
    do_read("R8 timeout", 8'h00, 32'h0AA0_A123, 0, 1'b0,
            32'h0, 8'h80, 32'hFFFF_FFFF, 1);
    t_bad_wlen();
    t_bad_rlen();
    t_bad_cmd();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule